// File: doc/BRIEF.md
# Decrement-and-Skip Execution Unit

This unit executes two byte-oriented instructions of an 8-bit core. Both take a file register and subtract one from it. One skips the next instruction when the 8-bit result is zero. The other skips when the result is non-zero. The result goes either back to the register or to the working register W, and no status flag changes. Each instruction cycle lasts four clocks, named phases Q1 to Q4. The unit decodes in Q1, reads the operand in Q2, subtracts in Q3 and writes back in Q4.

A skip throws away the instruction that fetch has already brought in and runs empty cycles in its place. The `flush` output stays high for each of these cycles. There is one empty cycle for a single-word instruction. There are two when the prefetched word opens a two-word instruction. The file registers live in a small banked store inside the unit. An access-bank path covers the low part of bank 0 and the top of the special-function page. A bank-select register supplies the bank for banked access. A host port loads and reads the store, W and the bank-select register. A separate flag marks accesses that the extended addressing mode would redirect. The unit only raises this flag and still uses the access bank.

Top module: `dsk_unit`

## Requirements
- R1: An instruction is taken only when `ins_word[15:10]` is 6'b001011 (skip if zero) or 6'b010011 (skip if not zero). Bit 9 is the destination bit d, bit 8 is the bank bit a, and bits 7:0 are the register address f. Any other word gives no write-back and no flush.
- R2: After reset, `phase` counts 0,1,2,3 and then repeats. `ins_word` is sampled at the clock edge that ends phase 0. `wb_valid` is high only during phase 3 of an executing cycle.
- R3: The result is the operand minus one, modulo 256, so 0x00 gives 0xFF. With d=1 the result is written to the register and W keeps its value. With d=0 the result goes to W, the register keeps its value, and `wb_to_w` is 1.
- R4: With a=0, an f below 0x60 addresses 0x000+f and an f of 0x60 or more addresses 0xF00+f. With a=1, the address is {bsr, f}.
- R5: The zero form skips when the 8-bit result is 0. The non-zero form skips when the result is not 0. Without a skip, no flush cycle follows.
- R6: A skip gives two flush cycles when the prefetched word (`next_op` = bits 15:6) begins a two-word instruction, and one flush cycle otherwise. Two-word starts are 4'b1100 in the top bits, 7'b1110110, 8'b11101111, and 10'b1110111000.
- R7: During a flush cycle a valid instruction on `ins_word` is ignored. It causes no write-back and changes no register.
- R8: `idx_hit` is high in phases 1 to 3 of an executing cycle exactly when `ext_en`=1, a=0 and f is 0x5F or less. The access itself still uses the access bank.
- R9: Reset clears W, the bank-select register, `flush`, any pending skip and `phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Active-low reset |
| ins_valid | input | 1 | `ins_word` holds an instruction |
| ins_word | input | 16 | Instruction word from fetch |
| next_op | input | 10 | Bits 15:6 of the prefetched word |
| ext_en | input | 1 | Extended addressing mode enabled |
| h_we | input | 1 | Host write strobe |
| h_sel | input | 2 | Host target: 0 store, 1 W, 2 bank select |
| h_addr | input | 12 | Host store address, also the read address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Store contents at `h_addr` |
| phase | output | 2 | Current phase, 0 = Q1 |
| wb_valid | output | 1 | Write-back happening this Q4 |
| wb_to_w | output | 1 | Write-back goes to W |
| wb_addr | output | 12 | Data address of the operand |
| wb_data | output | 8 | Decremented value |
| flush | output | 1 | Discard the prefetched instruction this cycle |
| idx_hit | output | 1 | Access falls in the extended-mode indexed window |
| w_out | output | 8 | Working register |
| bsr_out | output | 4 | Bank-select register |

## Verification
The bench wraps 0x00 to 0xFF under the non-zero form. A design that tested the skip on the original value instead of the result would skip there wrongly. It sends two-word prefetches of every listed kind, and a two-word prefetch when no skip happens. A unit that ignored the word length would flush once too few times, or would flush with no skip at all. It places f on both sides of the 0x60 split and uses a=1 with a non-zero bank, so a wrong access-bank map or a missing bank-select shows up in `wb_addr`. It also offers an instruction during a flush cycle and resets during a pending skip. A unit that executed squashed cycles would change the register, and one that kept the pending skip through reset would go on flushing.

// File: rtl/dsk_unit.sv
module dsk_unit #(
  parameter int NBANK  = 2,
  parameter int SFR_LO = 8'h60,
  parameter int IDX_HI = 8'h5F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ins_valid,
  input  logic [15:0] ins_word,
  input  logic [9:0]  next_op,
  input  logic        ext_en,
  input  logic        h_we,
  input  logic [1:0]  h_sel,
  input  logic [11:0] h_addr,
  input  logic [7:0]  h_wdata,
  output logic [7:0]  h_rdata,
  output logic [1:0]  phase,
  output logic        wb_valid,
  output logic        wb_to_w,
  output logic [11:0] wb_addr,
  output logic [7:0]  wb_data,
  output logic        flush,
  output logic        idx_hit,
  output logic [7:0]  w_out,
  output logic [3:0]  bsr_out
);
  localparam int GPR_N = NBANK * 256;
  localparam int SFR_N = 256 - SFR_LO;
  localparam int GW    = $clog2(GPR_N);
  localparam int SW    = $clog2(SFR_N);

  logic [7:0]  gpr [GPR_N];
  logic [7:0]  sfr [SFR_N];
  logic [1:0]  q;
  logic        act, nz_r, d_r, idx_r;
  logic [11:0] addr_r;
  logic [7:0]  rd_r, res_r, w_r;
  logic [3:0]  bsr_r;
  logic [1:0]  sq;

  function automatic logic in_gpr(input logic [11:0] a);
    return 32'(a[11:8]) < NBANK;
  endfunction

  function automatic logic in_sfr(input logic [11:0] a);
    return a[11:8] == 4'hF && 32'(a[7:0]) >= SFR_LO;
  endfunction

  function automatic logic [SW-1:0] sfr_idx(input logic [7:0] lo);
    logic [7:0] off;
    off = lo - 8'(SFR_LO);
    return off[SW-1:0];
  endfunction

  function automatic logic [7:0] rd(input logic [11:0] a);
    if (in_gpr(a)) return gpr[a[GW-1:0]];
    if (in_sfr(a)) return sfr[sfr_idx(a[7:0])];
    return 8'h00;
  endfunction

  function automatic logic two_word(input logic [9:0] op);
    return op[9:6] == 4'b1100 || op[9:3] == 7'b1110110 ||
           op[9:2] == 8'b11101111 || op == 10'b1110111000;
  endfunction

  wire        is_z   = ins_word[15:10] == 6'b001011;
  wire        is_nz  = ins_word[15:10] == 6'b010011;
  wire        dec_a  = ins_word[8];
  wire [7:0]  dec_f  = ins_word[7:0];
  wire [11:0] dec_addr = dec_a ? {bsr_r, dec_f}
                       : (32'(dec_f) < SFR_LO ? {4'h0, dec_f} : {4'hF, dec_f});
  wire        skip   = nz_r ? (res_r != 8'h00) : (res_r == 8'h00);
  wire        core_we = act && q == 2'd3 && d_r;

  assign phase    = q;
  assign flush    = sq != 2'd0;
  assign wb_valid = act && q == 2'd3;
  assign wb_to_w  = !d_r;
  assign wb_addr  = addr_r;
  assign wb_data  = res_r;
  assign idx_hit  = act && idx_r;
  assign w_out    = w_r;
  assign bsr_out  = bsr_r;
  assign h_rdata  = rd(h_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= 2'd0;
      act    <= 1'b0;
      nz_r   <= 1'b0;
      d_r    <= 1'b1;
      idx_r  <= 1'b0;
      addr_r <= '0;
      rd_r   <= '0;
      res_r  <= '0;
      w_r    <= '0;
      bsr_r  <= '0;
      sq     <= '0;
    end else begin
      q <= q + 2'd1;
      case (q)
        2'd0: begin
          act    <= !flush && ins_valid && (is_z || is_nz);
          nz_r   <= is_nz;
          d_r    <= ins_word[9];
          addr_r <= dec_addr;
          idx_r  <= ext_en && !dec_a && 32'(dec_f) <= IDX_HI;
        end
        2'd1: rd_r  <= rd(addr_r);
        2'd2: res_r <= rd_r - 8'd1;
        default: begin
          act <= 1'b0;
          if (act) begin
            if (skip) sq <= two_word(next_op) ? 2'd2 : 2'd1;
          end else if (sq != 2'd0) begin
            sq <= sq - 2'd1;
          end
        end
      endcase
      if (act && q == 2'd3 && !d_r) w_r <= res_r;
      else if (h_we && h_sel == 2'd1) w_r <= h_wdata;
      if (h_we && h_sel == 2'd2) bsr_r <= h_wdata[3:0];
    end
  end

  wire        m_we = core_we || (h_we && h_sel == 2'd0);
  wire [11:0] m_a  = core_we ? addr_r : h_addr;
  wire [7:0]  m_d  = core_we ? res_r : h_wdata;

  always_ff @(posedge clk) begin
    if (m_we && in_gpr(m_a)) gpr[m_a[GW-1:0]] <= m_d;
    if (m_we && in_sfr(m_a)) sfr[sfr_idx(m_a[7:0])] <= m_d;
  end
endmodule

module dsk_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       wb_valid,
  input logic       flush,
  input logic       idx_hit
);
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == $past(phase) + 2'd1);
  // R2
  wb_in_q4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> phase == 2'd3);
  // R5
  flush_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> $past(wb_valid));
  // R7
  no_wb_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !wb_valid);
  // R8
  idx_not_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_hit |-> phase != 2'd0);
  // R6
  flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && phase == 2'd0) |-> !wb_valid);
endmodule

bind dsk_unit dsk_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase),
  .wb_valid(wb_valid), .flush(flush), .idx_hit(idx_hit)
);

// File: tb/dsk_unit_tb.sv
module dsk_unit_tb;
  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ext_en = 0, h_we = 0;
  logic [15:0] ins_word = 0;
  logic [9:0] next_op = 0;
  logic [1:0] h_sel = 0;
  logic [11:0] h_addr = 0;
  logic [7:0] h_wdata = 0;
  logic [7:0] h_rdata, wb_data, w_out;
  logic [1:0] phase;
  logic wb_valid, wb_to_w, flush, idx_hit;
  logic [11:0] wb_addr;
  logic [3:0] bsr_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dsk_unit u_dut (.*);

  // ins, next word, initial value, bank select
  localparam logic [43:0] VEC [10] = '{
    {16'h2E10, 16'h0000, 8'h05, 4'h0},
    {16'h2E20, 16'h0000, 8'h01, 4'h0},
    {16'h2F30, 16'hEF12, 8'h01, 4'h1},
    {16'h2C65, 16'hC123, 8'h01, 4'h0},
    {16'h4E40, 16'hEC00, 8'h00, 4'h0},
    {16'h4F08, 16'hEF00, 8'h01, 4'h1},
    {16'h4C7F, 16'hEE05, 8'h80, 4'h0},
    {16'h2E5F, 16'hEF00, 8'h00, 4'h0},
    {16'h4E11, 16'h0E05, 8'h03, 4'h0},
    {16'h2E61, 16'hED40, 8'h01, 4'h1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] sel, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    h_we = 1; h_sel = sel; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_we = 0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [7:0] d);
    h_addr = a;
    #1 d = h_rdata;
  endtask

  task automatic to_q1;
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
  endtask

  function automatic bit is2w(input logic [15:0] w);
    return w[15:12] == 4'hC || w[15:9] == 7'b1110110 || w[15:8] == 8'hEF ||
           w[15:6] == 10'b1110111000;
  endfunction

  task automatic exec(input logic [15:0] ins, input logic [15:0] nxt,
                      input logic [7:0] init, input logic [3:0] bsr, input logic ext);
    logic d, a, nz, skip, eidx;
    logic [7:0] f, res, v;
    logic [11:0] adr;
    int nsq, n;
    d = ins[9]; a = ins[8]; f = ins[7:0];
    nz = ins[15:10] == 6'b010011;
    adr = a ? {bsr, f} : (f < 8'h60 ? {4'h0, f} : {4'hF, f});
    res = init - 8'd1;
    skip = nz ? (res != 0) : (res == 0);
    nsq = skip ? (is2w(nxt) ? 2 : 1) : 0;
    eidx = ext && !a && f <= 8'h5F;
    hwr(2'd1, 12'h0, 8'h5A);
    hwr(2'd2, 12'h0, {4'h0, bsr});
    hwr(2'd0, adr, init);
    to_q1();
    ins_valid = 1; ins_word = ins; next_op = nxt[15:6]; ext_en = ext;
    @(negedge clk); ins_valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk(wb_valid == 1, "R2 wb_valid in Q4", wb_valid, 1);
    chk(wb_addr == adr, "R4 address", wb_addr, adr);
    chk(wb_data == res, "R3 result", wb_data, res);
    chk(wb_to_w == !d, "R3 destination", wb_to_w, !d);
    chk(idx_hit == eidx, "R8 indexed flag", idx_hit, eidx);
    @(negedge clk);
    n = 0;
    while (flush && n < 5) begin
      n++;
      repeat (4) @(negedge clk);
    end
    chk(n == nsq, "R5 R6 flush cycles", n, nsq);
    hrd(adr, v);
    if (d) begin
      chk(v == res, "R3 register written", v, res);
      chk(w_out == 8'h5A, "R3 W kept", w_out, 8'h5A);
    end else begin
      chk(w_out == res, "R3 W written", w_out, res);
      chk(v == init, "R3 register kept", v, init);
    end
    ext_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(w_out == 0 && bsr_out == 0, "R9 reset regs", {w_out, bsr_out}, 0);
    chk(flush == 0 && wb_valid == 0 && phase == 0, "R9 reset flush", flush, 0);
    rst_n = 1;

    for (int i = 0; i < 10; i++)
      exec(VEC[i][43:28], VEC[i][27:12], VEC[i][11:4], VEC[i][3:0], 1'b0);

    // R8 indexed window
    exec(16'h2E20, 16'h0000, 8'h07, 4'h0, 1'b1);
    exec(16'h2E60, 16'h0000, 8'h07, 4'h0, 1'b1);
    exec(16'h2F10, 16'h0000, 8'h07, 4'h1, 1'b1);

    // R1 other opcode ignored
    hwr(2'd0, 12'h010, 8'h33);
    to_q1();
    ins_valid = 1; ins_word = 16'h2A10;
    @(negedge clk); ins_valid = 0;
    repeat (2) @(negedge clk);
    chk(wb_valid == 0, "R1 no write-back", wb_valid, 0);
    @(negedge clk);
    chk(flush == 0, "R1 no flush", flush, 0);
    hrd(12'h010, v);
    chk(v == 8'h33, "R1 register kept", v, 8'h33);

    // R7 instruction during flush ignored
    hwr(2'd0, 12'h020, 8'h01);
    to_q1();
    ins_valid = 1; ins_word = 16'h2E20; next_op = 10'h000;
    @(negedge clk); ins_valid = 0;
    repeat (3) @(negedge clk);
    chk(flush == 1, "R5 flush after skip", flush, 1);
    ins_valid = 1; ins_word = 16'h2E10;
    @(negedge clk); ins_valid = 0;
    repeat (2) @(negedge clk);
    chk(wb_valid == 0, "R7 no write-back in flush", wb_valid, 0);
    @(negedge clk);
    hrd(12'h010, v);
    chk(v == 8'h33, "R7 register kept", v, 8'h33);
    chk(flush == 0, "R6 single flush", flush, 0);

    // R9 reset during pending skip
    hwr(2'd1, 12'h0, 8'h44);
    hwr(2'd2, 12'h0, 8'h01);
    hwr(2'd0, 12'h020, 8'h01);
    to_q1();
    ins_valid = 1; ins_word = 16'h2E20; next_op = 10'h3BC;
    @(negedge clk); ins_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(flush == 0, "R9 flush cleared", flush, 0);
    chk(w_out == 0 && bsr_out == 0, "R9 regs cleared", {w_out, bsr_out}, 0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    chk(flush == 0, "R9 no pending skip", flush, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule